// File: doc/BRIEF.md
# Four-Stack Operand and Writeback Core

This block is the execution core of a small stack-oriented processor. It keeps four hardware LIFO stacks and a small ALU. Each instruction names one stack as the primary operand P and one as the secondary operand S. Any stack may fill either role, and both roles may name the same stack. The two operands are read from the stack tops. Either operand may also be consumed: its pop bit removes the entry in the same cycle. The ALU result is then pushed onto the primary stack.

Two-operand operations compute from P and S and write only to P. Single-operand operations read S and push onto P, so data can move from one stack to another as part of the operation. An instruction is accepted in any cycle where its valid strobe is high, and it completes in that cycle. The top value, fill count and sticky overflow and underflow flags of every stack are visible at the ports.

Top module: `quad_stack_core`

## Requirements
- R1: The 16-bit instruction is decoded as follows. Bits [15:14] select the primary stack and bits [13:12] select the secondary stack. Bit 11 pops the primary operand and bit 10 pops the secondary operand. Bits [9:0] hold the operation code: 0 NOP, 1 ADD, 2 SUB, 3 AND, 4 OR, 5 XOR, 6 NOT, 7 COPY.
- R2: Each stack holds up to 8 entries. The fill count of a stack never exceeds 8, and the top value of an empty stack reads as zero.
- R3: A valid operation with codes 1 to 7 pushes its result onto the primary stack. An operand whose pop bit is clear stays on its stack.
- R4: ADD computes P+S and SUB computes P-S, both modulo 2^32. AND, OR and XOR are bitwise on P and S.
- R5: NOT pushes the bitwise complement of S onto P, and COPY pushes S onto P. A pop of S therefore moves the value between stacks.
- R6: While the valid strobe is low, no stack, count or flag changes.
- R7: Both operands are sampled before any pop, and pops take effect before the push. Pop plus push on P replaces its top in place. When P and S name the same stack and both pop bits are set, two entries are removed before the push.
- R8: NOP and every code above 7 neither push nor pop, whatever the pop bits say.
- R9: A push onto a full stack drops the value, leaves the stack unchanged and sets that stack's sticky overflow flag.
- R10: A pop from an empty stack yields zero as the operand and sets that stack's sticky underflow flag. A stack's count never goes below zero.
- R11: After reset, every count is zero and every flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | Instruction strobe |
| instr | input | 16 | Instruction word |
| topOut | output | 4*DW | Top value of stack k at bits [k*DW +: DW] |
| depthOut | output | 4*CW | Fill count of stack k at bits [k*CW +: CW] (CW=4 for depth 8) |
| ovfFlags | output | 4 | Sticky overflow flag, one bit per stack |
| udfFlags | output | 4 | Sticky underflow flag, one bit per stack |

## Verification
The pop and the push can hit the same stack in one cycle. The bench provokes this in three ways. A subtraction pops its own primary stack, and the top must be replaced while the depth stays the same. Both operands name one stack with both pop bits set, and the depth must drop by one net, with the result computed from the pre-pop top. A move takes its operand from an empty stack, and both the zero operand and the raised underflow flag are judged at the ports.

// File: rtl/qstk_pkg.sv
package qstk_pkg;
  localparam int NSTK  = 4;
  localparam int SEL_W = $clog2(NSTK);
  localparam int OP_W  = 10;

  localparam logic [2:0] FN_ADD  = 3'd1;
  localparam logic [2:0] FN_SUB  = 3'd2;
  localparam logic [2:0] FN_AND  = 3'd3;
  localparam logic [2:0] FN_OR   = 3'd4;
  localparam logic [2:0] FN_XOR  = 3'd5;
  localparam logic [2:0] FN_NOT  = 3'd6;
  localparam logic [2:0] FN_COPY = 3'd7;

  typedef struct packed {
    logic             push;
    logic             popP;
    logic             popS;
    logic [SEL_W-1:0] selP;
    logic [SEL_W-1:0] selS;
    logic [2:0]       func;
  } ctrlStrobes_t;
endpackage

// File: rtl/qstk_ctrl.sv
module qstk_ctrl
  import qstk_pkg::*;
(
  input  logic         instrValid,
  input  logic [15:0]  instr,
  output ctrlStrobes_t strobes
);
  logic [OP_W-1:0] opField;
  logic            known;

  assign opField = instr[OP_W-1:0];
  assign known   = (opField != '0) && (opField <= OP_W'(7));

  always_comb begin
    strobes.push = instrValid && known;
    strobes.popP = instrValid && known && instr[11];
    strobes.popS = instrValid && known && instr[10];
    strobes.selP = instr[15:14];
    strobes.selS = instr[13:12];
    strobes.func = opField[2:0];
  end
endmodule

// File: rtl/qstk_datapath.sv
module qstk_datapath
  import qstk_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  output logic [NSTK*DW-1:0] topOut,
  output logic [NSTK*CW-1:0] depthOut,
  output logic [NSTK-1:0]    ovfFlags,
  output logic [NSTK-1:0]    udfFlags
);
  logic [DW-1:0] opP, opS, aluRes;

  assign opP = topOut[strobes.selP*DW +: DW];
  assign opS = topOut[strobes.selS*DW +: DW];

  always_comb begin
    unique case (strobes.func)
      FN_ADD:  aluRes = opP + opS;
      FN_SUB:  aluRes = opP - opS;
      FN_AND:  aluRes = opP & opS;
      FN_OR:   aluRes = opP | opS;
      FN_XOR:  aluRes = opP ^ opS;
      FN_NOT:  aluRes = ~opS;
      FN_COPY: aluRes = opS;
      default: aluRes = '0;
    endcase
  end

  for (genvar g = 0; g < NSTK; g++) begin : gStk
    logic [DW-1:0] slot [DEPTH];
    logic [CW-1:0] cnt, topIdx, popN, afterPop;
    logic          ovf, udf, pushHere, short, full;

    assign topIdx   = cnt - CW'(1);
    assign popN     = CW'(strobes.popP && (strobes.selP == SEL_W'(g)))
                    + CW'(strobes.popS && (strobes.selS == SEL_W'(g)));
    assign short    = popN > cnt;
    assign afterPop = short ? '0 : cnt - popN;
    assign pushHere = strobes.push && (strobes.selP == SEL_W'(g));
    assign full     = afterPop == CW'(DEPTH);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt <= '0;
        ovf <= 1'b0;
        udf <= 1'b0;
      end else begin
        if (short) udf <= 1'b1;
        if (pushHere && full) ovf <= 1'b1;
        if (pushHere && !full) cnt <= afterPop + CW'(1);
        else if (!pushHere || full) cnt <= (pushHere && full) ? cnt : afterPop;
      end
    end

    always_ff @(posedge clk) begin
      if (pushHere && !full) slot[afterPop[AW-1:0]] <= aluRes;
    end

    assign topOut[g*DW +: DW]   = (cnt == '0) ? '0 : slot[topIdx[AW-1:0]];
    assign depthOut[g*CW +: CW] = cnt;
    assign ovfFlags[g]          = ovf;
    assign udfFlags[g]          = udf;
  end
endmodule

// File: rtl/quad_stack_core.sv
module quad_stack_core
  import qstk_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [15:0]        instr,
  output logic [4*DW-1:0]    topOut,
  output logic [4*CW-1:0]    depthOut,
  output logic [3:0]         ovfFlags,
  output logic [3:0]         udfFlags
);
  ctrlStrobes_t strobes;

  qstk_ctrl u_ctrl (
    .instrValid(instrValid),
    .instr     (instr),
    .strobes   (strobes)
  );

  qstk_datapath #(.DW(DW), .DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .topOut  (topOut),
    .depthOut(depthOut),
    .ovfFlags(ovfFlags),
    .udfFlags(udfFlags)
  );
endmodule

// File: rtl/quad_stack_core_chk.sv
module quad_stack_core_chk #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            instrValid,
  input logic [15:0]     instr,
  input logic [4*DW-1:0] topOut,
  input logic [4*CW-1:0] depthOut,
  input logic [3:0]      ovfFlags,
  input logic [3:0]      udfFlags
);
  logic [1:0]    selP;
  logic [CW-1:0] pDepth;
  logic          unusedOp, plainAdd;

  assign selP     = instr[15:14];
  assign pDepth   = depthOut[selP*CW +: CW];
  assign unusedOp = (instr[9:0] == 10'd0) || (instr[9:0] > 10'd7);
  assign plainAdd = (instr[9:0] == 10'd1) && !instr[11] && !instr[10];

  for (genvar k = 0; k < 4; k++) begin : gBound
    a_r2_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
      depthOut[k*CW +: CW] <= CW'(DEPTH));
  end

  a_r3_push_grows: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && plainAdd && pDepth < CW'(DEPTH))
      |=> depthOut[$past(selP)*CW +: CW] == $past(pDepth) + CW'(1));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> ($stable(depthOut) && $stable(topOut) && $stable(ovfFlags) && $stable(udfFlags)));

  a_r8_unused_hold: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && unusedOp) |=> ($stable(depthOut) && $stable(topOut)));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ((ovfFlags & $past(ovfFlags)) == $past(ovfFlags)));

  a_r10_udf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ((udfFlags & $past(udfFlags)) == $past(udfFlags)));
endmodule

bind quad_stack_core quad_stack_core_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .instrValid(instrValid),
  .instr     (instr),
  .topOut    (topOut),
  .depthOut  (depthOut),
  .ovfFlags  (ovfFlags),
  .udfFlags  (udfFlags)
);

// File: tb/sim_quad_stack_core.sv
`timescale 1ns/1ps
module sim_quad_stack_core;
  localparam int DW = 32;
  localparam int CW = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            instrValid = 1'b0;
  logic [15:0]     instr = '0;
  logic [4*DW-1:0] topOut;
  logic [4*CW-1:0] depthOut;
  logic [3:0]      ovfFlags, udfFlags;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  quad_stack_core u0 (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instr(instr),
    .topOut(topOut), .depthOut(depthOut), .ovfFlags(ovfFlags), .udfFlags(udfFlags)
  );

  function automatic logic [15:0] mk(input int p, input int s, input bit pp, input bit ps, input int op);
    return {2'(p), 2'(s), pp, ps, 10'(op)};
  endfunction

  // vector: instr, stack to inspect, expected top, expected depth
  typedef struct packed {
    logic [15:0] ins;
    logic [1:0]  stk;
    logic [31:0] top;
    logic [3:0]  dep;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{mk(0,1,0,0,6), 2'd0, 32'hFFFF_FFFF, 4'd1},  // R5 NOT from empty S
    '{mk(0,0,0,0,1), 2'd0, 32'hFFFF_FFFE, 4'd2},  // R4 ADD wraps
    '{mk(1,0,0,0,6), 2'd1, 32'h0000_0001, 4'd1},  // R5 NOT across stacks
    '{mk(1,1,0,0,1), 2'd1, 32'h0000_0002, 4'd2},  // R3 push, no pop
    '{mk(1,0,1,0,2), 2'd1, 32'h0000_0004, 4'd2},  // R7 SUB replaces top
    '{mk(2,1,0,1,7), 2'd2, 32'h0000_0004, 4'd1},  // R5 COPY moves
    '{mk(1,2,0,0,4), 2'd1, 32'h0000_0005, 4'd2},  // R4 OR
    '{mk(3,1,0,0,3), 2'd3, 32'h0000_0000, 4'd1},  // R4 AND
    '{mk(3,1,1,0,5), 2'd3, 32'h0000_0005, 4'd1},  // R4 XOR
    '{mk(1,1,1,1,2), 2'd1, 32'h0000_0000, 4'd1},  // R7 double pop
    '{mk(0,0,1,1,10'h3FF), 2'd0, 32'hFFFF_FFFE, 4'd2}, // R8 unused code
    '{mk(0,0,1,0,0), 2'd0, 32'hFFFF_FFFE, 4'd2}   // R8 NOP with pop bit
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w, input bit v);
    @(negedge clk);
    instr = w;
    instrValid = v;
    @(negedge clk);
    instrValid = 1'b0;
  endtask

  function automatic logic [31:0] topOf(input int k);
    return topOut[k*DW +: DW];
  endfunction

  function automatic logic [31:0] depOf(input int k);
    return 32'(depthOut[k*CW +: CW]);
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #800000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    for (int k = 0; k < 4; k++) begin
      chk("R11 depth", depOf(k), 0);
      chk("R2 empty top", topOf(k), 0);
    end
    chk("R11 flags", {24'd0, ovfFlags, udfFlags}, 0);
    rstN = 1'b1;

    // R1 encoding walked through the vector table
    for (int i = 0; i < 12; i++) begin
      issue(VEC[i].ins, 1'b1);
      chk($sformatf("R1 vec%0d top", i), topOf(VEC[i].stk), VEC[i].top);
      chk($sformatf("R1 vec%0d depth", i), depOf(VEC[i].stk), 32'(VEC[i].dep));
    end

    // R6 valid low: nothing moves
    issue(mk(0,0,1,1,1), 1'b0);
    chk("R6 idle depth", depOf(0), 2);
    chk("R6 idle top", topOf(0), 32'hFFFF_FFFE);

    // R9 fill stack 2 (depth 1, top 4) to full, then one more
    for (int i = 0; i < 7; i++) issue(mk(2,2,0,0,7), 1'b1);
    chk("R2 full depth", depOf(2), 8);
    chk("R9 no flag yet", 32'(ovfFlags), 0);
    issue(mk(2,2,0,0,1), 1'b1);
    chk("R9 overflow depth", depOf(2), 8);
    chk("R9 overflow top", topOf(2), 4);
    chk("R9 overflow flag", 32'(ovfFlags), 32'h4);

    // R10 empty stack 1, then pop it as S
    issue(mk(3,1,0,1,7), 1'b1);
    chk("R10 drained", depOf(1), 0);
    chk("R10 no flag yet", 32'(udfFlags), 0);
    issue(mk(0,1,0,1,6), 1'b1);
    chk("R10 zero operand", topOf(0), 32'hFFFF_FFFF);
    chk("R10 push depth", depOf(0), 3);
    chk("R10 empty stays", depOf(1), 0);
    chk("R10 underflow flag", 32'(udfFlags), 32'h2);
    issue(mk(0,0,0,0,0), 1'b1);
    chk("R10 sticky", 32'(udfFlags), 32'h2);
    chk("R9 sticky", 32'(ovfFlags), 32'h4);

    // R11 reset again clears everything
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R11 reset depth", depOf(2), 0);
    chk("R11 reset flags", {24'd0, ovfFlags, udfFlags}, 0);
    finishRun();
  end
endmodule